// File: doc/BRIEF.md
# Two-Layer Pulse-Width Network Sequencer

This controller runs a pulse-width neural network built from two external analogue synapse arrays. Each array has eight inputs and eight outputs. A host first fills an input-width table in a small on-board memory and then raises `start`. The sequencer then works through a fixed series of phases. It drives eight pulses into the first array, holding each high for its stored width. It then enables that array's threshold ramp and times the eight output pulses that come back. It stores those widths, replays them as the input pulses of the second array, enables the second ramp, and stores the final widths. At the end it raises `done`, and the host reads the results.

All widths are 8-bit counts of a time base tick. The tick fires once every `tickDiv + 1` clock cycles. A ramp phase closes as soon as every channel has finished its pulse, or when the elapsed tick count reaches `timeoutTicks`, whichever comes first. The memory has three regions, all reachable through one host port: input widths, layer-one results and layer-two results.

Top module: `pwseq_top`

## Requirements
- R1: While reset is held, `done`, both ramp enables and all sixteen pulse outputs are low.
- R2: Host address bits [4:3] choose the region (0 input widths, 1 layer-one results, 2 layer-two results, 3 unused) and bits [2:0] choose the channel; `hostRdata` shows the addressed entry combinationally, region 3 reads as zero, and a write with `hostWe` lands only in region 0 while the sequencer is idle or finished.
- R3: `start` is taken only when idle or finished; the next cycle `done` is low, and host writes made while a run is in progress change nothing.
- R4: In the layer-one drive phase all channels with a nonzero width rise together in the phase's first cycle, and channel i stays high for exactly width×(`tickDiv`+1) cycles; a width of zero never pulses, and no channel rises later in the phase.
- R5: When all layer-one drive pulses are low, `l1RampEn` rises. Each response channel counts the ticks during which it is high, from its first high cycle until its first low cycle after that. The count saturates at 255, and any later pulse on that channel is ignored.
- R6: The ramp phase ends when every channel has finished or the elapsed tick count equals `timeoutTicks`; the counts are then written to region 1, a channel that never pulsed stores 0, and an unfinished channel keeps its partial count.
- R7: The layer-two drive phase replays the region-1 widths on `l2Pulse` with the same timing rule as R4, starting the cycle after the layer-one ramp closes.
- R8: The layer-two ramp phase measures `l2Resp` by the rules of R5 and R6, stores the counts to region 2, and raises `done` in the cycle after it closes.
- R9: At most one of these is active in any cycle: layer-one pulses, layer-one ramp, layer-two pulses, layer-two ramp, `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (idle or finished only) |
| tickDiv | input | 8 | Time base: one tick per tickDiv+1 cycles |
| timeoutTicks | input | 16 | Ramp phase limit in ticks |
| hostWe | input | 1 | Host write strobe |
| hostAddr | input | 5 | Host address: region in [4:3], channel in [2:0] |
| hostWdata | input | 8 | Host write data |
| hostRdata | output | 8 | Addressed memory entry |
| done | output | 1 | Run complete, results readable |
| l1Pulse | output | 8 | Input pulses to the first array |
| l1RampEn | output | 1 | Threshold ramp enable, first array |
| l1Resp | input | 8 | Output pulses of the first array |
| l2Pulse | output | 8 | Input pulses to the second array |
| l2RampEn | output | 1 | Threshold ramp enable, second array |
| l2Resp | input | 8 | Output pulses of the second array |

## Verification
The assertions watch the phase ordering on every cycle. Only one kind of activity may appear at a time. The drive pulses may only fall once they have started. Each ramp must follow the low end of its drive phase, `done` must come straight out of the second ramp, and `start` must clear `done`. Pulse lengths, the stored counts, saturation, the timeout cut-off, the ignoring of a second response pulse and the blocking of host writes all depend on data. The bench shows these by timing the pulses it observes and reading the memory back after each run.

// File: rtl/pwseq_pkg.sv
package pwseq_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_DRIVE1,
    PH_RAMP1,
    PH_DRIVE2,
    PH_RAMP2,
    PH_FINISH
  } phase_t;

  // Strobes and levels from control to datapath
  typedef struct packed {
    logic clear;     // phase change: restart time base and measurement
    logic drive;     // a drive phase is running
    logic measure;   // a ramp phase is running
    logic layerTwo;  // current phase belongs to the second array
    logic store;     // write measured counts into the result region
    logic hostOpen;  // host writes permitted
  } seqCtrl_t;

endpackage

// File: rtl/pwseq_ctrl.sv
module pwseq_ctrl
  import pwseq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     anyActive,
  input  logic     allDone,
  input  logic     timedOut,
  output seqCtrl_t ctl,
  output logic     l1RampEn,
  output logic     l2RampEn,
  output logic     done
);

  phase_t phase, nextPhase;
  logic rampClose;

  assign rampClose = allDone || timedOut;

  always_comb begin
    nextPhase = phase;
    unique case (phase)
      PH_IDLE, PH_FINISH: if (start) nextPhase = PH_DRIVE1;
      PH_DRIVE1:          if (!anyActive) nextPhase = PH_RAMP1;
      PH_RAMP1:           if (rampClose) nextPhase = PH_DRIVE2;
      PH_DRIVE2:          if (!anyActive) nextPhase = PH_RAMP2;
      PH_RAMP2:           if (rampClose) nextPhase = PH_FINISH;
      default:            nextPhase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= nextPhase;
  end

  always_comb begin
    ctl.clear    = (nextPhase != phase);
    ctl.drive    = (phase == PH_DRIVE1) || (phase == PH_DRIVE2);
    ctl.measure  = (phase == PH_RAMP1) || (phase == PH_RAMP2);
    ctl.layerTwo = (phase == PH_DRIVE2) || (phase == PH_RAMP2);
    ctl.store    = ctl.measure && rampClose;
    ctl.hostOpen = (phase == PH_IDLE) || (phase == PH_FINISH);
  end

  assign l1RampEn = (phase == PH_RAMP1);
  assign l2RampEn = (phase == PH_RAMP2);
  assign done     = (phase == PH_FINISH);

endmodule

// File: rtl/pwseq_datapath.sv
module pwseq_datapath
  import pwseq_pkg::*;
#(
  parameter int CH = 8,
  parameter int W  = 8,
  parameter int TW = 16,
  localparam int CH_BITS   = $clog2(CH),
  localparam int ADDR_BITS = CH_BITS + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqCtrl_t             ctl,
  input  logic [W-1:0]         tickDiv,
  input  logic [TW-1:0]        timeoutTicks,
  input  logic                 hostWe,
  input  logic [ADDR_BITS-1:0] hostAddr,
  input  logic [W-1:0]         hostWdata,
  output logic [W-1:0]         hostRdata,
  input  logic [CH-1:0]        l1Resp,
  input  logic [CH-1:0]        l2Resp,
  output logic [CH-1:0]        l1Pulse,
  output logic [CH-1:0]        l2Pulse,
  output logic                 anyActive,
  output logic                 allDone,
  output logic                 timedOut
);

  logic [W-1:0]  inBank  [CH];
  logic [W-1:0]  midBank [CH];
  logic [W-1:0]  outBank [CH];
  logic [W-1:0]  measCnt [CH];
  logic [CH-1:0] seenHigh, finished, active, respSel;
  logic [W-1:0]  prescale;
  logic [TW-1:0] elapsed;
  logic          tick;
  logic [1:0]         hostRegion;
  logic [CH_BITS-1:0] hostChan;

  assign tick       = (prescale == tickDiv);
  assign hostRegion = hostAddr[ADDR_BITS-1 -: 2];
  assign hostChan   = hostAddr[CH_BITS-1:0];

  // Per-channel drive comparison and response select
  for (genvar g = 0; g < CH; g++) begin : gChan
    logic [W-1:0] drvWidth;
    assign drvWidth   = ctl.layerTwo ? midBank[g] : inBank[g];
    assign active[g]  = (elapsed < TW'(drvWidth));
    assign respSel[g] = ctl.layerTwo ? l2Resp[g] : l1Resp[g];
  end

  assign anyActive = |active;
  assign l1Pulse   = (ctl.drive && !ctl.layerTwo) ? active : '0;
  assign l2Pulse   = (ctl.drive &&  ctl.layerTwo) ? active : '0;
  assign allDone   = &finished;
  assign timedOut  = (elapsed == timeoutTicks);

  // Time base and elapsed-tick counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prescale <= '0;
      elapsed  <= '0;
    end else if (ctl.clear) begin
      prescale <= '0;
      elapsed  <= '0;
    end else if (ctl.drive || ctl.measure) begin
      if (tick) begin
        prescale <= '0;
        if (elapsed != '1) elapsed <= elapsed + 1'b1;
      end else begin
        prescale <= prescale + 1'b1;
      end
    end
  end

  // Response width measurement
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenHigh <= '0;
      finished <= '0;
      for (int c = 0; c < CH; c++) measCnt[c] <= '0;
    end else if (ctl.clear) begin
      seenHigh <= '0;
      finished <= '0;
      for (int c = 0; c < CH; c++) measCnt[c] <= '0;
    end else if (ctl.measure) begin
      for (int c = 0; c < CH; c++) begin
        seenHigh[c] <= seenHigh[c] | respSel[c];
        finished[c] <= finished[c] | (seenHigh[c] & ~respSel[c]);
        if (tick && respSel[c] && !finished[c] && measCnt[c] != '1)
          measCnt[c] <= measCnt[c] + 1'b1;
      end
    end
  end

  // Width memory: three regions
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < CH; c++) begin
        inBank[c]  <= '0;
        midBank[c] <= '0;
        outBank[c] <= '0;
      end
    end else begin
      if (ctl.hostOpen && hostWe && hostRegion == 2'd0)
        inBank[hostChan] <= hostWdata;
      if (ctl.store) begin
        for (int c = 0; c < CH; c++) begin
          if (ctl.layerTwo) outBank[c] <= measCnt[c];
          else              midBank[c] <= measCnt[c];
        end
      end
    end
  end

  always_comb begin
    unique case (hostRegion)
      2'd0:    hostRdata = inBank[hostChan];
      2'd1:    hostRdata = midBank[hostChan];
      2'd2:    hostRdata = outBank[hostChan];
      default: hostRdata = '0;
    endcase
  end

endmodule

// File: rtl/pwseq_top.sv
module pwseq_top
  import pwseq_pkg::*;
#(
  parameter int CH = 8,
  parameter int W  = 8,
  parameter int TW = 16,
  localparam int ADDR_BITS = $clog2(CH) + 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 start,
  input  logic [W-1:0]         tickDiv,
  input  logic [TW-1:0]        timeoutTicks,
  input  logic                 hostWe,
  input  logic [ADDR_BITS-1:0] hostAddr,
  input  logic [W-1:0]         hostWdata,
  output logic [W-1:0]         hostRdata,
  output logic                 done,
  output logic [CH-1:0]        l1Pulse,
  output logic                 l1RampEn,
  input  logic [CH-1:0]        l1Resp,
  output logic [CH-1:0]        l2Pulse,
  output logic                 l2RampEn,
  input  logic [CH-1:0]        l2Resp
);

  seqCtrl_t ctl;
  logic anyActive, allDone, timedOut;

  pwseq_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .anyActive(anyActive), .allDone(allDone), .timedOut(timedOut),
    .ctl(ctl), .l1RampEn(l1RampEn), .l2RampEn(l2RampEn), .done(done)
  );

  pwseq_datapath #(.CH(CH), .W(W), .TW(TW)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .tickDiv(tickDiv), .timeoutTicks(timeoutTicks),
    .hostWe(hostWe), .hostAddr(hostAddr), .hostWdata(hostWdata),
    .hostRdata(hostRdata), .l1Resp(l1Resp), .l2Resp(l2Resp),
    .l1Pulse(l1Pulse), .l2Pulse(l2Pulse),
    .anyActive(anyActive), .allDone(allDone), .timedOut(timedOut)
  );

endmodule

// File: rtl/pwseq_checks.sv
module pwseq_checks #(
  parameter int CH = 8
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          done,
  input logic [CH-1:0] l1Pulse,
  input logic [CH-1:0] l2Pulse,
  input logic          l1RampEn,
  input logic          l2RampEn
);

  assert_single_activity_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({|l1Pulse, l1RampEn, |l2Pulse, l2RampEn, done}));

  assert_no_late_rise_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(|l1Pulse) && (|l1Pulse)) |-> ((l1Pulse & ~$past(l1Pulse)) == '0));

  assert_ramp_after_drive_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(l1RampEn) |-> ($past(l1Pulse) == '0));

  assert_replay_after_ramp_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(|l2Pulse) |-> $past(l1RampEn));

  assert_done_after_ramp_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(l2RampEn));

  assert_start_clears_done_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && start) |=> !done);

endmodule

bind pwseq_top pwseq_checks #(.CH(CH)) uChecks (
  .clk(clk), .rstN(rstN), .start(start), .done(done),
  .l1Pulse(l1Pulse), .l2Pulse(l2Pulse),
  .l1RampEn(l1RampEn), .l2RampEn(l2RampEn)
);

// File: tb/pwseq_top_test.sv
module pwseq_top_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 3;

  typedef struct packed {
    logic [63:0] inW;
    logic [79:0] len1;
    logic [79:0] len2;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{inW: 64'h0807060504030201,
      len1: {10'd25, 10'd22, 10'd19, 10'd16, 10'd13, 10'd10, 10'd7, 10'd4},
      len2: {8{10'd10}}},
    '{inW: 64'h111111111111ff00,
      len1: {10'd9, 10'd9, 10'd70, 10'd9, 10'd9, 10'd9, 10'd9, 10'd0},
      len2: {10'd8, 10'd7, 10'd6, 10'd5, 10'd4, 10'd3, 10'd2, 10'd1}},
    '{inW: 64'hc8c8c8c8c8c8c8c8,
      len1: {8{10'd20}},
      len2: {10'd40, 10'd40, 10'd40, 10'd40, 10'd40, 10'd0, 10'd40, 10'd40}}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  tickDiv = '0;
  logic [15:0] timeoutTicks = 16'd60;
  logic        hostWe = 1'b0;
  logic [4:0]  hostAddr = '0;
  logic [7:0]  hostWdata = '0;
  logic [7:0]  hostRdata;
  logic        done;
  logic [7:0]  l1Pulse, l2Pulse;
  logic        l1RampEn, l2RampEn;
  logic [7:0]  l1Resp = '0;
  logic [7:0]  l2Resp = '0;

  int total = 0;
  int fails = 0;
  int cycles = 0;
  int len1 [8];
  int len2 [8];
  int cnt1 [8];
  int cnt2 [8];
  int k1 = 0;
  int k2 = 0;
  bit secondPulse = 1'b0;

  pwseq_top uut (
    .clk(clk), .rstN(rstN), .start(start), .tickDiv(tickDiv),
    .timeoutTicks(timeoutTicks), .hostWe(hostWe), .hostAddr(hostAddr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .done(done),
    .l1Pulse(l1Pulse), .l1RampEn(l1RampEn), .l1Resp(l1Resp),
    .l2Pulse(l2Pulse), .l2RampEn(l2RampEn), .l2Resp(l2Resp)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      total++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  function automatic bit respAt(int k, int len, bit sec);
    return (k >= 2 && k < 2 + len) || (sec && k >= 2 + len + 3 && k < 2 + len + 8);
  endfunction

  function automatic int minOf(int a, int b);
    return (a < b) ? a : b;
  endfunction

  // Model of the external arrays' output pulses: start 2 cycles into the ramp
  always @(negedge clk) begin
    if (l1RampEn) begin
      for (int i = 0; i < 8; i++) l1Resp[i] <= respAt(k1, len1[i], secondPulse && i == 0);
      k1++;
    end else begin
      k1 = 0;
      l1Resp <= '0;
    end
    if (l2RampEn) begin
      for (int i = 0; i < 8; i++) l2Resp[i] <= respAt(k2, len2[i], 1'b0);
      k2++;
    end else begin
      k2 = 0;
      l2Resp <= '0;
    end
    for (int i = 0; i < 8; i++) begin
      if (l1Pulse[i]) cnt1[i]++;
      if (l2Pulse[i]) cnt2[i]++;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hostWrite(input int a, input int d);
    @(negedge clk);
    hostWe = 1'b1; hostAddr = 5'(a); hostWdata = 8'(d);
    @(negedge clk);
    hostWe = 1'b0;
  endtask

  task automatic hostRead(input int a, output int v);
    hostAddr = 5'(a);
    #1;
    v = int'(hostRdata);
  endtask

  task automatic runVec(input logic [63:0] inW, input logic [79:0] l1L,
                        input logic [79:0] l2L, input int tmo, input int div,
                        input bit sec, input bit intrude, input string tag);
    int v;
    int e1;
    int e2;
    timeoutTicks = 16'(tmo);
    tickDiv = 8'(div);
    secondPulse = sec;
    for (int i = 0; i < 8; i++) begin
      len1[i] = int'(l1L[i*10 +: 10]);
      len2[i] = int'(l2L[i*10 +: 10]);
      hostWrite(i, int'(inW[i*8 +: 8]));
    end
    for (int i = 0; i < 8; i++) begin
      cnt1[i] = 0;
      cnt2[i] = 0;
    end
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " R3 done low after start"}, int'(done), 0);
    if (intrude) hostWrite(0, 99);
    while (!done) @(negedge clk);
    if (intrude) begin
      hostRead(0, v);
      check({tag, " R3 write during run ignored"}, v, int'(inW[7:0]));
    end
    for (int i = 0; i < 8; i++) begin
      e1 = minOf(minOf(len1[i], tmo - 2), 255);
      e2 = minOf(minOf(len2[i], tmo - 2), 255);
      check({tag, " R4 layer-one drive length"}, cnt1[i], int'(inW[i*8 +: 8]) * (div + 1));
      hostRead(8 + i, v);
      check({tag, " R5 R6 layer-one stored width"}, v, e1);
      check({tag, " R7 layer-two replay length"}, cnt2[i], e1 * (div + 1));
      hostRead(16 + i, v);
      check({tag, " R8 layer-two stored width"}, v, e2);
    end
  endtask

  initial begin
    int v;
    for (int i = 0; i < 8; i++) begin
      len1[i] = 0; len2[i] = 0; cnt1[i] = 0; cnt2[i] = 0;
    end
    // R1: reset state
    @(negedge clk);
    @(negedge clk);
    check("R1 done in reset", int'(done), 0);
    check("R1 layer-one pulses in reset", int'(l1Pulse), 0);
    check("R1 layer-two pulses in reset", int'(l2Pulse), 0);
    check("R1 ramps in reset", int'({l1RampEn, l2RampEn}), 0);
    rstN = 1'b1;

    // R2: region decoding and write protection
    hostWrite(3, 77);
    hostRead(3, v);
    check("R2 region-0 write", v, 77);
    hostWrite(8, 170);
    hostRead(8, v);
    check("R2 region-1 write ignored", v, 0);
    hostWrite(24, 5);
    hostRead(24, v);
    check("R2 region-3 reads zero", v, 0);

    // Table of vectors
    for (int n = 0; n < NV; n++)
      runVec(VECS[n].inW, VECS[n].len1, VECS[n].len2, 60, 0, 1'b0, 1'b0, "table");

    // R3: host write during a run, restart from finished
    runVec(VECS[0].inW, VECS[0].len1, VECS[0].len2, 60, 0, 1'b0, 1'b1, "intrude");

    // R5: second response pulse on channel 0 ignored
    runVec(64'h0202020202020202,
           {10'd30, 10'd30, 10'd30, 10'd30, 10'd30, 10'd30, 10'd30, 10'd5},
           {8{10'd3}}, 60, 0, 1'b1, 1'b0, "second-pulse R5");

    // R5 saturation at 255 with a long timeout, R6 zero for silent channels
    runVec(64'h0101010101010101,
           {10'd0, 10'd0, 10'd0, 10'd0, 10'd300, 10'd0, 10'd0, 10'd0},
           {8{10'd0}}, 400, 0, 1'b0, 1'b0, "saturate R5");

    // R4 time base divider: width 4 at tickDiv 2 gives 12 cycles
    runVec(64'h0000000000000004, {8{10'd0}}, {8{10'd0}}, 5, 2, 1'b0, 1'b0, "divider R4");

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule